// File: doc/BRIEF.md
# Feedback Triple-Redundant Counter

This block is a free-running binary counter hardened against single-event upsets by triplication. Three identical count registers run side by side. A bitwise two-of-three majority voter combines them into the count seen by the rest of the chip. In feedback mode, every replica computes its next value from the voted count rather than from its own register. A replica whose state was flipped is therefore pulled back into agreement on the following clock, while the counter keeps running and needs no reset.

A simple mode, selected by a level input, lets each replica advance from its own stored value. In that mode a corrupted replica stays divergent until a reset, or until feedback mode is selected again. The voter still hides a single bad replica from the output. The simple mode exists so the two schemes can be compared on the same hardware.

Per-replica disagreement flags show which registers currently differ from the voted value. A combined flag reports that more than one replica disagrees. Test inputs XOR an arbitrary mask into any subset of replicas on a strobe, so upsets can be injected on demand.

Top module: `tmr_counter`

## Requirements
- R1: While `rst` is high at a rising edge, all three replicas load zero. After that edge `count_o` is 0 and `mismatch_o` is 3'b000. Reset overrides `en` and `inj_stb`.
- R2: With `en` high and no fault present, `count_o` rises by exactly one per clock and wraps from 2^W-1 to 0.
- R3: With `en` low and no fault present, `count_o` keeps its value.
- R4: Injection works as follows. When `inj_stb[i]` is high at a rising edge, replica i loads its normal next value XOR `inj_mask[i*W +: W]`. When only one replica is corrupted, `count_o` still follows the counting of R2 and R3.
- R5: `mismatch_o[i]` is high exactly while replica i's register differs from the voted count.
- R6: With `fb_mode` = 1, every replica loads the voted value plus `en` at each edge. After a clock with no strobe, all mismatch flags are therefore low, whatever faults were present before.
- R7: With `fb_mode` = 0, each replica advances from its own register. A replica that diverged keeps its `mismatch_o` bit high on every following clock until reset or feedback mode.
- R8: `multi_fault_o` is high when two or more bits of `mismatch_o` are high. Two replicas flipped in different bit positions in the same cycle raise it, and the voted count stays correct.
- R9: Two replicas flipped in the same bit position in the same cycle make `count_o` wrong. The event is still detected, because the untouched replica's `mismatch_o` bit goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| fb_mode | input | 1 | 1: replicas advance from the voted value; 0: each replica advances from its own register |
| inj_stb | input | 3 | Per-replica fault strobe, bit i targets replica i |
| inj_mask | input | 3*W | Flip masks, replica i uses bits [i*W +: W] |
| count_o | output | W | Voted count |
| mismatch_o | output | 3 | Replica i disagrees with the voted count |
| multi_fault_o | output | 1 | Two or more replicas disagree with the voted count |

## Verification
The counting and hold properties assume that at most one replica is struck per cycle and that every replica agrees with the vote beforehand. Simultaneous double strikes can legitimately corrupt the vote. The stimulus keeps double strikes to isolated directed rows, and each such row is followed by a strike-free clock in feedback mode before any counting check relies on agreement. The persistence property for simple mode assumes the mode input stays low while no strike occurs, so the bench changes mode only on rows where that property's antecedent is not in play.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NREP = 3;

    typedef enum logic {
        MODE_SIMPLE   = 1'b0,
        MODE_FEEDBACK = 1'b1
    } tmr_mode_t;

    function automatic logic bit_maj(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic int unsigned ones3(input logic [NREP-1:0] v);
        int unsigned n;
        n = 0;
        for (int k = 0; k < NREP; k++) begin
            n += int'(v[k]);
        end
        return n;
    endfunction

endpackage

// File: rtl/tmr_replica.sv
module tmr_replica
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  tmr_mode_t     mode,
    input  logic [W-1:0]  voted,
    input  logic          inj_stb,
    input  logic [W-1:0]  inj_mask,
    output logic [W-1:0]  q
);

    logic [W-1:0] base;
    logic [W-1:0] step;
    logic [W-1:0] nxt;

    always_comb begin
        base = (mode == MODE_FEEDBACK) ? voted : q;
        step = en ? base + W'(1) : base;
        nxt  = inj_stb ? (step ^ inj_mask) : step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NREP-1:0][W-1:0] reps,
    output logic [W-1:0]           voted,
    output logic [NREP-1:0]        disagree,
    output logic                   multi
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign voted[b] = bit_maj(reps[0][b], reps[1][b], reps[2][b]);
    end

    for (genvar r = 0; r < NREP; r++) begin : g_cmp
        assign disagree[r] = (reps[r] != voted);
    end

    assign multi = (ones3(disagree) >= 2);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8,
    localparam int MW = NREP * W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             fb_mode,
    input  logic [NREP-1:0]  inj_stb,
    input  logic [MW-1:0]    inj_mask,
    output logic [W-1:0]     count_o,
    output logic [NREP-1:0]  mismatch_o,
    output logic             multi_fault_o
);

    tmr_mode_t                mode;
    logic [NREP-1:0][W-1:0]   reps;
    logic [W-1:0]             voted;

    assign mode = tmr_mode_t'(fb_mode);

    for (genvar r = 0; r < NREP; r++) begin : g_rep
        tmr_replica #(.W(W)) u_rep (
            .clk      (clk),
            .rst      (rst),
            .en       (en),
            .mode     (mode),
            .voted    (voted),
            .inj_stb  (inj_stb[r]),
            .inj_mask (inj_mask[r*W +: W]),
            .q        (reps[r])
        );
    end

    tmr_voter #(.W(W)) u_vote (
        .reps     (reps),
        .voted    (voted),
        .disagree (mismatch_o),
        .multi    (multi_fault_o)
    );

    assign count_o = voted;

endmodule

// File: rtl/tmr_counter_chk.sv
module tmr_counter_chk #(
    parameter int W = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          fb_mode,
    input logic [2:0]    inj_stb,
    input logic [W-1:0]  count_o,
    input logic [2:0]    mismatch_o,
    input logic          multi_fault_o
);

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count_o == '0 && mismatch_o == 3'b000));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && inj_stb == 3'b000 && mismatch_o == 3'b000)
        |=> count_o == $past(count_o) + W'(1));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && $countones(inj_stb) <= 1 && mismatch_o == 3'b000)
        |=> $stable(count_o));

    assert_single_masked_R4: assert property (@(posedge clk) disable iff (rst)
        (en && $countones(inj_stb) == 1 && mismatch_o == 3'b000)
        |=> count_o == $past(count_o) + W'(1));

    assert_resync_R6: assert property (@(posedge clk) disable iff (rst)
        (fb_mode && inj_stb == 3'b000) |=> mismatch_o == 3'b000);

    assert_divergence_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (!fb_mode && mismatch_o != 3'b000 && inj_stb == 3'b000)
        |=> mismatch_o != 3'b000);

    assert_multi_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (inj_stb == 3'b000 && mismatch_o == 3'b000) |=> !multi_fault_o);

endmodule

bind tmr_counter tmr_counter_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .fb_mode       (fb_mode),
    .inj_stb       (inj_stb),
    .count_o       (count_o),
    .mismatch_o    (mismatch_o),
    .multi_fault_o (multi_fault_o)
);

// File: tb/tmr_counter_bench.sv
module tmr_counter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NV = 13;

    // row: en | fb | stb[2:0] | bit0 | bit1 | bit2 | count[7:0] | mismatch[2:0] | multi
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 1'b1, 3'b000, 3'd0, 3'd0, 3'd0, 8'd1,   3'b000, 1'b0},
        {1'b1, 1'b1, 3'b001, 3'd3, 3'd0, 3'd0, 8'd2,   3'b001, 1'b0},
        {1'b1, 1'b1, 3'b000, 3'd0, 3'd0, 3'd0, 8'd3,   3'b000, 1'b0},
        {1'b0, 1'b1, 3'b010, 3'd0, 3'd0, 3'd0, 8'd3,   3'b010, 1'b0},
        {1'b0, 1'b1, 3'b000, 3'd0, 3'd0, 3'd0, 8'd3,   3'b000, 1'b0},
        {1'b1, 1'b1, 3'b011, 3'd1, 3'd2, 3'd0, 8'd4,   3'b011, 1'b1},
        {1'b1, 1'b1, 3'b000, 3'd0, 3'd0, 3'd0, 8'd5,   3'b000, 1'b0},
        {1'b1, 1'b0, 3'b100, 3'd0, 3'd0, 3'd7, 8'd6,   3'b100, 1'b0},
        {1'b1, 1'b0, 3'b000, 3'd0, 3'd0, 3'd0, 8'd7,   3'b100, 1'b0},
        {1'b1, 1'b0, 3'b000, 3'd0, 3'd0, 3'd0, 8'd8,   3'b100, 1'b0},
        {1'b1, 1'b1, 3'b000, 3'd0, 3'd0, 3'd0, 8'd9,   3'b000, 1'b0},
        {1'b1, 1'b1, 3'b011, 3'd0, 3'd0, 3'd0, 8'd11,  3'b100, 1'b0},
        {1'b1, 1'b1, 3'b000, 3'd0, 3'd0, 3'd0, 8'd12,  3'b000, 1'b0}
    };

    localparam string TAG [NV] = '{
        "R2", "R4 R5", "R6", "R3 R5", "R6", "R8", "R6",
        "R4 R7", "R7", "R7", "R6", "R9", "R6"
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic             fb_mode = 1'b1;
    logic [2:0]       inj_stb = 3'b000;
    logic [3*W-1:0]   inj_mask = '0;
    logic [W-1:0]     count_o;
    logic [2:0]       mismatch_o;
    logic             multi_fault_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_counter #(.W(W)) u_tmr_counter (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .fb_mode       (fb_mode),
        .inj_stb       (inj_stb),
        .inj_mask      (inj_mask),
        .count_o       (count_o),
        .mismatch_o    (mismatch_o),
        .multi_fault_o (multi_fault_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic e, input logic f, input logic [2:0] s,
                         input logic [2:0] b0, input logic [2:0] b1, input logic [2:0] b2);
        @(negedge clk);
        en       = e;
        fb_mode  = f;
        inj_stb  = s;
        inj_mask = {W'(1) << b2, W'(1) << b1, W'(1) << b0};
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick();
        tick();
        check("R1", "count after reset", 32'(count_o), 32'd0);
        check("R1", "mismatch after reset", 32'(mismatch_o), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][25], VEC[i][24], VEC[i][23:21],
                  VEC[i][20:18], VEC[i][17:15], VEC[i][14:12]);
            tick();
            check(TAG[i], "count", 32'(count_o), 32'(VEC[i][11:4]));
            check(TAG[i], "mismatch", 32'(mismatch_o), 32'(VEC[i][3:1]));
            check(TAG[i], "multi", 32'(multi_fault_o), 32'(VEC[i][0]));
        end

        // R1: reset overrides enable and strobes on every replica
        @(negedge clk);
        rst = 1'b1; en = 1'b1; inj_stb = 3'b111; inj_mask = '1;
        tick();
        check("R1", "count with strobe during reset", 32'(count_o), 32'd0);
        check("R1", "mismatch with strobe during reset", 32'(mismatch_o), 32'd0);
        @(negedge clk);
        rst = 1'b0; inj_stb = 3'b000; inj_mask = '0; fb_mode = 1'b0; en = 1'b1;

        // R2: wrap in simple mode after a full cycle
        for (int k = 0; k < 255; k++) tick();
        check("R2", "count at top", 32'(count_o), 32'd255);
        tick();
        check("R2", "count after wrap", 32'(count_o), 32'd0);
        check("R2", "mismatch after wrap", 32'(mismatch_o), 32'd0);

        // R3: hold in simple mode
        @(negedge clk);
        en = 1'b0;
        tick();
        tick();
        check("R3", "count held", 32'(count_o), 32'd0);

        // R7: divergence then reset clears it
        drive(1'b1, 1'b0, 3'b010, 3'd0, 3'd5, 3'd0);
        tick();
        check("R7", "mismatch after strike", 32'(mismatch_o), 32'b010);
        drive(1'b1, 1'b0, 3'b000, 3'd0, 3'd0, 3'd0);
        tick();
        check("R7", "mismatch persists", 32'(mismatch_o), 32'b010);
        check("R4", "voted count masked", 32'(count_o), 32'd2);
        @(negedge clk);
        rst = 1'b1;
        tick();
        check("R1", "reset clears divergence", 32'(mismatch_o), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule